// File: doc/BRIEF.md
# Parallel Printer Output Port

This block is a bus-slave port that hands bytes to a parallel printer. A bus master starts a transfer by placing an address and a read/write flag on the bus. When the upper address bits match the port's base address, the port raises an internal start pulse one clock later. A two-state timing machine then answers with a one-cycle slave-ready pulse on the third clock of the transfer.

The lowest address bit picks the target. A write to the even address loads an 8-bit data register whose outputs drive the printer data pins. A read of the odd address returns a single ready bit that shows whether the printer reports itself idle. Each load raises a strobe toward the printer. The strobe stays high until the printer shows that it has taken the byte by dropping its idle line.

Writes are never refused. Software is expected to poll the ready bit before each write.

Top module: `prn_out_port`

## Requirements
- R1: After reset, `bus_ready`, `prn_valid`, `prn_data` and `bus_rdata` are all 0.
- R2: A transfer whose address has `bus_addr[ADDR_W-1:1]` equal to `BASE_ADDR[ADDR_W-1:1]` in cycle 1 gets `bus_ready` high in cycle 3 only. It is low in cycles 1, 2 and 4.
- R3: A transfer to any other address never raises `bus_ready` and leaves `prn_data` and `prn_valid` unchanged.
- R4: A write (`bus_rw`=0) with `bus_addr[0]`=0 loads the `bus_wdata` value held in cycle 2 into the data register. The value appears on `prn_data` in cycle 3, and `prn_valid` is 1 from then on.
- R5: A read (`bus_rw`=1) with `bus_addr[0]`=1 returns the ready bit in `bus_rdata[0]` with bits 7..1 at 0 during the `bus_ready` cycle. `bus_rdata` is 0 in every other cycle.
- R6: The ready bit equals `prn_idle` after `SYNC_STAGES` clock edges of synchronisation.
- R7: `prn_valid` stays 1 until the synchronised `prn_idle` falls from 1 to 0. It then clears.
- R8: A write while the ready bit is 0 is still accepted and overwrites `prn_data`.
- R9: A write to the odd address leaves `prn_data` unchanged. A read of the even address returns 0. Both still receive `bus_ready`.
- R10: A new transfer may start in the cycle right after `bus_ready`, and it is served in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address, held in cycles 1-2 of a transfer |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | DATA_W | Write data, held in cycles 1-2 |
| bus_rdata | output | DATA_W | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Slave-ready pulse, cycle 3 |
| prn_data | output | DATA_W | Printer data pins |
| prn_valid | output | 1 | New-byte strobe to the printer |
| prn_idle | input | 1 | Printer idle, asynchronous |

## Verification
The bench times `bus_ready` against its own cycle count for each transfer, including transfers issued back to back. A machine that lingered in its answering state, or that restarted from a held start pulse, would show a wrong or doubled pulse there. Accesses with a mismatched address and accesses with a mismatched low bit are checked at `prn_data` and `bus_rdata`, which catches a decoder that ignores bit 0 or the upper bits. The strobe is watched while the printer stays idle and after it drops idle, so a strobe that cleared on a level rather than a fall would be seen. A write issued while the printer is busy must still replace the byte, which catches a port that wrongly blocks writes.

// File: rtl/prn_pkg.sv
package prn_pkg;
  typedef enum logic {
    ST_IDLE    = 1'b0,
    ST_RESPOND = 1'b1
  } prn_state_e;
endpackage

// File: rtl/prn_addr_dec.sv
module prn_addr_dec #(
  parameter int          ADDR_W    = 32,
  parameter logic [31:0] BASE_ADDR = 32'hFFFF_0010
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic              sel_status
);
  localparam logic [ADDR_W-1:0] BASE = BASE_ADDR[ADDR_W-1:0];

  always_comb begin
    hit        = (addr[ADDR_W-1:1] == BASE[ADDR_W-1:1]);
    sel_status = addr[0];
  end
endmodule

// File: rtl/prn_timing.sv
module prn_timing
  import prn_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hit,
  input  logic rw,
  input  logic sel_status,
  output logic go,
  output logic respond,
  output logic rw_q,
  output logic sel_q
);
  prn_state_e state_q, state_d;
  logic       go_d;
  logic       cap_en;

  // A start pulse is only issued from the idle state, once per address phase
  always_comb begin
    cap_en = hit && (state_q == ST_IDLE) && !go;
    go_d   = cap_en;
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:    if (go) state_d = ST_RESPOND;
      ST_RESPOND: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      go      <= 1'b0;
    end else begin
      state_q <= state_d;
      go      <= go_d;
    end
  end

  // Access kind is captured together with the start pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rw_q  <= 1'b0;
      sel_q <= 1'b0;
    end else if (cap_en) begin
      rw_q  <= rw;
      sel_q <= sel_status;
    end
  end

  assign respond = (state_q == ST_RESPOND);
endmodule

// File: rtl/prn_sync.sv
module prn_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out,
  output logic fell
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];
  end

  assign sync_out = chain_q[STAGES-1];
  assign fell     = last_q && !chain_q[STAGES-1];
endmodule

// File: rtl/prn_handshake.sv
module prn_handshake #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] wdata,
  input  logic              idle_fell,
  output logic [DATA_W-1:0] data_q,
  output logic              valid_q
);
  logic valid_d;

  always_comb begin
    valid_d = valid_q;
    if (idle_fell) valid_d = 1'b0;
    if (load)      valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    data_q <= '0;
    else if (load) data_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= 1'b0;
    else        valid_q <= valid_d;
  end
endmodule

// File: rtl/prn_out_port.sv
module prn_out_port #(
  parameter int          ADDR_W      = 32,
  parameter int          DATA_W      = 8,
  parameter logic [31:0] BASE_ADDR   = 32'hFFFF_0010,
  parameter int          SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rw,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_ready,
  output logic [DATA_W-1:0] prn_data,
  output logic              prn_valid,
  input  logic              prn_idle
);
  logic addr_hit, sel_status;
  logic go, rw_q, sel_q;
  logic load;
  logic sout, idle_fell;

  prn_addr_dec #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_dec (
    .addr(bus_addr), .hit(addr_hit), .sel_status(sel_status)
  );

  prn_timing u_timing (
    .clk(clk), .rst_n(rst_n), .hit(addr_hit), .rw(bus_rw),
    .sel_status(sel_status), .go(go), .respond(bus_ready),
    .rw_q(rw_q), .sel_q(sel_q)
  );

  prn_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(prn_idle),
    .sync_out(sout), .fell(idle_fell)
  );

  assign load = go && !rw_q && !sel_q;

  prn_handshake #(.DATA_W(DATA_W)) u_hs (
    .clk(clk), .rst_n(rst_n), .load(load), .wdata(bus_wdata),
    .idle_fell(idle_fell), .data_q(prn_data), .valid_q(prn_valid)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_ready && rw_q && sel_q) bus_rdata = {{(DATA_W-1){1'b0}}, sout};
  end
endmodule

// File: rtl/prn_out_port_chk.sv
module prn_out_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_ready,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [DATA_W-1:0] prn_data,
  input logic              prn_valid,
  input logic              go,
  input logic              addr_hit,
  input logic              load,
  input logic              idle_fell
);
  assert_ready_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ready |=> !bus_ready);
  assert_go_then_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> bus_ready);
  assert_go_needs_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    go |-> $past(addr_hit));
  assert_rdata_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_ready |-> (bus_rdata == '0));
  assert_rdata_upper_R5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:1] == '0);
  assert_load_sets_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> prn_valid);
  assert_valid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (prn_valid && !idle_fell) |=> prn_valid);
  assert_data_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(prn_data));
endmodule

bind prn_out_port prn_out_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_ready(bus_ready), .bus_rdata(bus_rdata),
  .prn_data(prn_data), .prn_valid(prn_valid), .go(go), .addr_hit(addr_hit),
  .load(load), .idle_fell(idle_fell)
);

// File: tb/sim_prn_out_port.sv
`timescale 1ns/1ps
module sim_prn_out_port;
  localparam logic [31:0] BASE  = 32'hFFFF_0010;
  localparam logic [31:0] OTHER = 32'h0000_2000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [31:0] bus_addr;
  logic        bus_rw;
  logic [7:0]  bus_wdata, bus_rdata, prn_data;
  logic        bus_ready, prn_valid, prn_idle;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  prn_out_port u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rw(bus_rw),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_ready(bus_ready),
    .prn_data(prn_data), .prn_valid(prn_valid), .prn_idle(prn_idle)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One transfer; cycle 1 begins at the next falling edge
  task automatic xfer(input logic [31:0] a, input logic rw, input logic [7:0] wd,
                      input logic exp_rdy, input string req, output logic [7:0] rd);
    @(negedge clk);
    bus_addr = a; bus_rw = rw; bus_wdata = wd;
    chk({req, " ready cycle1"}, bus_ready, 0);
    @(negedge clk);
    chk({req, " ready cycle2"}, bus_ready, 0);
    @(negedge clk);
    chk({req, " ready cycle3"}, bus_ready, exp_rdy);
    rd = bus_rdata;
    bus_addr = OTHER; bus_rw = 1'b1; bus_wdata = 8'h00;
  endtask

  task automatic t_reset;
    chk("R1 ready", bus_ready, 0);
    chk("R1 valid", prn_valid, 0);
    chk("R1 data", prn_data, 0);
    chk("R1 rdata", bus_rdata, 0);
  endtask

  task automatic t_status_idle;
    logic [7:0] rd;
    prn_idle = 1'b1;
    idle_cycles(4);
    xfer(BASE | 32'h1, 1'b1, 8'h00, 1'b1, "R2 R5", rd);
    chk("R5 R6 status idle", rd, 8'h01);
    @(negedge clk);
    chk("R2 ready cycle4", bus_ready, 0);
    chk("R5 rdata outside ready", bus_rdata, 0);
  endtask

  task automatic t_write_basic;
    logic [7:0] rd;
    xfer(BASE, 1'b0, 8'hA5, 1'b1, "R2 R4", rd);
    chk("R4 data", prn_data, 8'hA5);
    chk("R4 valid", prn_valid, 1);
  endtask

  task automatic t_valid_handshake;
    logic [7:0] rd;
    idle_cycles(5);
    chk("R7 valid held while idle high", prn_valid, 1);
    prn_idle = 1'b0;
    idle_cycles(5);
    chk("R7 valid cleared after idle fell", prn_valid, 0);
    xfer(BASE | 32'h1, 1'b1, 8'h00, 1'b1, "R6", rd);
    chk("R6 status busy", rd, 8'h00);
  endtask

  task automatic t_overwrite_busy;
    logic [7:0] rd;
    xfer(BASE, 1'b0, 8'h3C, 1'b1, "R8", rd);
    chk("R8 overwrite while busy", prn_data, 8'h3C);
    chk("R8 valid", prn_valid, 1);
  endtask

  task automatic t_miss;
    logic [7:0] rd;
    xfer(OTHER, 1'b0, 8'hEE, 1'b0, "R3", rd);
    @(negedge clk);
    chk("R3 no ready late", bus_ready, 0);
    chk("R3 data unchanged", prn_data, 8'h3C);
    xfer(BASE ^ 32'h8000_0000, 1'b0, 8'hEE, 1'b0, "R3 high bit", rd);
    chk("R3 data unchanged high bit", prn_data, 8'h3C);
  endtask

  task automatic t_wrong_ops;
    logic [7:0] rd;
    xfer(BASE | 32'h1, 1'b0, 8'h77, 1'b1, "R9 write status", rd);
    @(negedge clk);
    chk("R9 status write ignored", prn_data, 8'h3C);
    prn_idle = 1'b1;
    idle_cycles(4);
    xfer(BASE, 1'b1, 8'h00, 1'b1, "R9 read data", rd);
    chk("R9 read of data address", rd, 8'h00);
  endtask

  task automatic t_back_to_back;
    logic [7:0] rd;
    xfer(BASE, 1'b0, 8'h11, 1'b1, "R10 first", rd);
    chk("R10 first data", prn_data, 8'h11);
    xfer(BASE, 1'b0, 8'h22, 1'b1, "R10 second", rd);
    chk("R10 second data", prn_data, 8'h22);
    xfer(BASE | 32'h1, 1'b1, 8'h00, 1'b1, "R10 third", rd);
    chk("R10 third status", rd, 8'h01);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = OTHER; bus_rw = 1'b1; bus_wdata = 8'h00; prn_idle = 1'b0;
    idle_cycles(3);
    t_reset();
    rst_n = 1'b1;
    idle_cycles(2);
    t_status_idle();
    t_write_basic();
    t_valid_handshake();
    t_overwrite_busy();
    t_miss();
    t_wrong_ops();
    t_back_to_back();
    idle_cycles(2);
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule